// File: doc/BRIEF.md
# Line-Locked Charge-Pump Clock Divider

This block produces the step-up clock for a charge-pump voltage converter. It divides the reference clock by a power of two chosen through a 3-bit ratio code. The division phase is tied to display line timing. A line counter runs for a programmable number of reference clocks per line. Each time that counter wraps, the divider restarts from the start of its high half. Every line therefore sees the same pump waveform, and the pump does not beat against the scan and cause visible flicker.

The block also drives a one-cycle line-start pulse, which marks the first cycle of each line. A new ratio code is taken only at a line boundary, so a line never holds a mix of two periods. If the division period is longer than a line, the restart cuts the waveform short at every line and its duty falls away from 50%. Software is expected to keep the pump frequency at or above the line rate.

Top module: `pump_clk_divider`

## Requirements
- R1: While reset is low, `pump_clk` is 1, `line_start` is 0 and the line counter is held at 0. The first line after reset release begins at count 0.
- R2: With a line setting L of 2 or more, the line counter runs from 0 to L-1 and then wraps to 0. `line_start` is 1 for exactly the one cycle in which the counter reads 0 after a wrap, so it pulses once every L cycles.
- R3: The counter wraps on any edge where count+1 is at least the setting. Settings 0 and 1 therefore give a one-cycle line, and `line_start` stays 1 on every cycle.
- R4: Ratio code 4 divides by 8, code 5 by 16 and code 6 by 32. Within each period of D cycles, `pump_clk` is 1 for the first D/2 cycles and 0 for the last D/2.
- R5: Codes below 4 divide by 8 and codes above 6 divide by 32.
- R6: The divider phase restarts at every line start. In the cycle `line_start` is 1, `pump_clk` is 1 and the division count is at 0, whatever the previous phase.
- R7: When the division period D exceeds the line length L, each line shows `pump_clk` high for min(D/2, L) cycles and low for the rest. For example, divide-by-32 with L=25 gives 16 cycles high and 9 low.
- R8: The ratio code is sampled only on the edge that starts a line. A change within a line does not alter the waveform until the next line.
- R9: From reset release until the first line start, the divider uses divide-by-8, whatever the ratio code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_len | input | LEN_W (5) | Reference clocks per line |
| ratio_code | input | CODE_W (3) | Division ratio select |
| pump_clk | output | 1 | Charge-pump step-up clock |
| line_start | output | 1 | One-cycle pulse on the first cycle of each line |

## Verification
Two cases are hardest to bring about from the ports. One is a ratio change that lands in the middle of a line. The other is a line shortened below the current count. In both, the deferred or immediate effect shows only in later cycles. The stimulus changes the ratio code and the line setting at chosen cycles inside a line. A cycle-accurate reference model in the bench samples the code only at its own line wraps, and every cycle is compared. Running divide-by-32 on a 25-clock line exercises the truncated waveform. Out-of-range codes and zero or one line settings cover saturation and the degenerate one-cycle line.

// File: rtl/pump_clk_divider.sv
module pump_clk_divider #(
  parameter int LEN_W    = 5,
  parameter int CODE_W   = 3,
  parameter int MIN_CODE = 4,
  parameter int MAX_CODE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  line_len,
  input  logic [CODE_W-1:0] ratio_code,
  output logic              pump_clk,
  output logic              line_start
);
  localparam int MIN_SHIFT = MIN_CODE - 1;
  localparam int MAX_SHIFT = MAX_CODE - 1;
  localparam int DIV_W     = MAX_SHIFT;
  localparam int SH_W      = $clog2(MAX_SHIFT + 1);

  logic [LEN_W-1:0] lcnt;
  logic [DIV_W-1:0] dcnt;
  logic [SH_W-1:0]  shift_q;
  logic [SH_W-1:0]  shift_d;
  logic             start_q;
  logic             wrap;
  logic [DIV_W-1:0] dmask;
  logic [DIV_W-1:0] half_sel;

  assign wrap = ({1'b0, lcnt} + (LEN_W+1)'(1)) >= {1'b0, line_len};

  always_comb begin
    if (int'(ratio_code) < MIN_CODE)      shift_d = SH_W'(MIN_SHIFT);
    else if (int'(ratio_code) > MAX_CODE) shift_d = SH_W'(MAX_SHIFT);
    else                                  shift_d = SH_W'(int'(ratio_code) - 1);
  end

  assign dmask    = DIV_W'((DIV_W+1)'(1) << shift_q) - DIV_W'(1);
  assign half_sel = dcnt >> (shift_q - SH_W'(1));
  assign pump_clk = ~half_sel[0];
  assign line_start = start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt    <= '0;
      dcnt    <= '0;
      shift_q <= SH_W'(MIN_SHIFT);
      start_q <= 1'b0;
    end else begin
      start_q <= wrap;
      if (wrap) begin
        lcnt    <= '0;
        dcnt    <= '0;
        shift_q <= shift_d;
      end else begin
        lcnt <= lcnt + LEN_W'(1);
        dcnt <= (dcnt + DIV_W'(1)) & dmask;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_state_R1: assert (pump_clk && !line_start && lcnt == '0)
        else $error("reset state violated");
    end
  end

  assert_start_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (lcnt == '0))
    else $error("line_start away from count 0");

  assert_phase_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (pump_clk && dcnt == '0))
    else $error("phase not restarted at line start");

  assert_ratio_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |-> $stable(shift_q))
    else $error("ratio changed inside a line");

  assert_ratio_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(shift_q) >= MIN_SHIFT) && (int'(shift_q) <= MAX_SHIFT))
    else $error("ratio outside supported range");

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dcnt & ~dmask) == '0)
    else $error("division count beyond period");
endmodule

// File: tb/sim_pump_clk_divider.sv
module sim_pump_clk_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] line_len = 5'd25;
  logic [2:0] ratio_code = 3'd6;
  logic       pump_clk;
  logic       line_start;

  typedef struct {
    bit    pump;
    bit    start;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;
  int m_lcnt = 0;
  int m_shift = 3;

  always #10 clk = ~clk;

  pump_clk_divider u0 (
    .clk(clk), .rst_n(rst_n), .line_len(line_len), .ratio_code(ratio_code),
    .pump_clk(pump_clk), .line_start(line_start)
  );

  function automatic int sat_shift(input int code);
    if (code < 4) return 3;
    if (code > 6) return 5;
    return code - 1;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input int code, input int len, input string tag);
    exp_t e;
    bit w;
    ratio_code = 3'(code);
    line_len   = 5'(len);
    w = (m_lcnt + 1 >= len);
    if (w) begin
      m_lcnt  = 0;
      m_shift = sat_shift(code);
    end else begin
      m_lcnt++;
    end
    e.start = w;
    e.pump  = (m_lcnt % (1 << m_shift)) < (1 << (m_shift - 1));
    e.tag   = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run(input int n, input int code, input int len, input string tag);
    for (int i = 0; i < n; i++) step(code, len, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(e.tag, "pump_clk", int'(pump_clk), int'(e.pump));
        check(e.tag == "R3" ? "R3" : "R2", "line_start", int'(line_start), int'(e.start));
      end
    end
  end

  initial begin : watchdog
    #(20 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check("R1", "pump_clk in reset", int'(pump_clk), 1);
    check("R1", "line_start in reset", int'(line_start), 0);
    rst_n = 1'b1;
    // first line after reset runs at divide-by-8 although code asks for 32
    run(25, 6, 25, "R9");
    // divide-by-32 on a 25-clock line: truncated waveform
    run(50, 6, 25, "R7");
    // mid-line switch to code 5 takes effect at next line only
    run(10, 6, 25, "R8");
    run(15, 5, 25, "R8");
    run(50, 5, 25, "R4");
    run(50, 4, 25, "R4");
    // exact fit: 16-clock line with divide-by-16
    run(48, 5, 16, "R6");
    // saturation below and above the supported range
    run(20, 1, 20, "R5");
    run(40, 0, 20, "R5");
    run(20, 7, 20, "R5");
    run(40, 7, 20, "R5");
    // shorten the line below the current count mid-line
    run(10, 4, 30, "R2");
    run(20, 4, 6, "R2");
    // degenerate line lengths
    run(8, 4, 1, "R3");
    run(8, 5, 0, "R3");
    run(30, 4, 12, "R6");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule